// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for a stalled system in two steps. Software programs a single 32-bit control word: a clock divider choice, one of four timeout lengths, and enables for counting, for the interrupt and for the reset request. Once enabled, a down-counter advances once per divided clock period. When it first runs out, the block raises an interrupt flag, optionally drives the interrupt output, and reloads a short fixed grace count. If software has still not cleared the flag when the grace count also runs out, and reset is enabled, the block records a reset flag and pulses a reset request towards the system reset logic.

Software keeps the watchdog quiet by writing the self-clearing restart bit, which reloads the full timeout. Both flags are cleared by writing 1 to them. Two reset inputs are provided. The core reset returns the control word to its default. The power-on reset also clears the reset flag, so that after a watchdog-caused core reset software can still see why the system restarted. The register port is a plain write strobe with data and a read bus that always shows the current word. It has no handshake, because every write completes in one cycle.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset the read word is 0x0000_0400 (divider select = 1, every other bit 0), and `irq` and `rst_req` are low.
- R2: A write stores divider select at bits 11:10, freeze enable at bit 9, count enable at bit 7, interrupt enable at bit 6, interval select at bits 5:4 and reset enable at bit 1. The new value is readable from the cycle after the write. Bits 31:12, 8 and 0 always read 0.
- R3: Writing 1 to bit 0 (restart) loads the counter with 2^(BASE + 2*S) divided ticks, where S is the interval select in that same write. The bit is never stored. An expiry in the same cycle as a restart is discarded.
- R4: Divider select values 0, 1, 2 and 3 make the counter step once every 1, 256, 2048 and 65536 clock cycles while count enable is 1.
- R5: When the counter runs out with the interrupt flag (bit 3) clear, the flag becomes 1 and the counter is reloaded with GRACE divided ticks. It then keeps counting.
- R6: `irq` equals the interrupt flag ANDed with interrupt enable.
- R7: When the counter runs out with the interrupt flag already 1 and reset enable set, the reset flag (bit 2) becomes 1 and `rst_req` is high for exactly one cycle. After this second expiry the counter stays at zero, whether or not reset is enabled, until the next restart.
- R8: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R9: Clearing count enable without a restart freezes the remaining count. Setting it again resumes from that count.
- R10: Core reset restores the R1 word and loads the counter with 2^BASE, but keeps the reset flag. Only power-on reset clears the reset flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| core_rst_n | input | 1 | Core reset, active low, keeps the reset flag |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written when `wr_en` is high |
| rd_data | output | 32 | Current control word |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A write lands at the next rising edge. Its fields and flag clears show on `rd_data` and `irq` from the falling edge after that edge. The first expiry is due N·D edges after the restart edge, where N is the interval count and D is the divider. The grace expiry follows GRACE·D edges later, and `rst_req` is high only in the cycle after that edge. The bench's behavioural model advances on each rising edge and is compared with the outputs on every falling edge. Timed checks count falling edges from the write, so the first expiry and the reset pulse are each sampled in their exact cycle and in the cycle before it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W      = 32;
  localparam int F_RESTART  = 0;
  localparam int F_RSTEN    = 1;
  localparam int F_RFLAG    = 2;
  localparam int F_IFLAG    = 3;
  localparam int F_ISEL     = 4;
  localparam int F_IE       = 6;
  localparam int F_EN       = 7;
  localparam int F_FRZ      = 9;
  localparam int F_CKSEL    = 10;
  localparam logic [1:0] CKSEL_RST = 2'd1;

  typedef struct packed {
    logic [1:0] cksel;
    logic       frz;
    logic       en;
    logic       ie;
    logic [1:0] isel;
    logic       iflag;
    logic       rst_en;
  } wdt_ctl_t;

  // log2 of the divider for each divider select value
  function automatic int unsigned div_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 8;
      2'd2:    return 11;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   lim;
  logic [PRE_W:0]   one_w;

  assign one_w = {{PRE_W{1'b0}}, 1'b1};
  assign lim   = (one_w << div_shift(sel)) - one_w;
  assign tick  = run && ({1'b0, pre_q} >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || clr || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R4
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pre_q == '0);
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W   = 21,
  parameter int GRACE   = 1024,
  parameter int RST_VAL = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             grace_go,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);
  localparam logic [CNT_W-1:0] RST_V   = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_V;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (grace_go) begin
      cnt_q <= GRACE_V;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R5
  grace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grace_go && !load) |=> cnt_q == GRACE_V);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !grace_go && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             expire,
  output wdt_ctl_t         ctl,
  output logic             restart,
  output logic             ev_first,
  output logic             ev_second,
  output logic             rst_req
);
  logic ev;

  assign restart   = wr_en && wr_data[F_RESTART];
  assign ev        = expire && !restart;
  assign ev_first  = ev && !ctl.iflag;
  assign ev_second = ev && ctl.iflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '{cksel: CKSEL_RST, default: '0};
      rst_req <= 1'b0;
    end else begin
      if (wr_en) begin
        ctl.cksel  <= wr_data[F_CKSEL +: 2];
        ctl.frz    <= wr_data[F_FRZ];
        ctl.en     <= wr_data[F_EN];
        ctl.ie     <= wr_data[F_IE];
        ctl.isel   <= wr_data[F_ISEL +: 2];
        ctl.rst_en <= wr_data[F_RSTEN];
      end
      ctl.iflag <= (ctl.iflag && !(wr_en && wr_data[F_IFLAG])) || ev_first;
      rst_req   <= ev_second && ctl.rst_en;
    end
  end

  // R5
  iflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> ctl.iflag);
  // R5
  iflag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.iflag) |-> $past(expire));
  // R8
  iflag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[F_IFLAG] && !ev_first) |=> !ctl.iflag);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int BASE  = 14,
  parameter int GRACE = 1024,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             core_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_req
);
  localparam int CNT_W = BASE + 7;

  logic             core_n;
  wdt_ctl_t         ctl;
  logic             restart, ev_first, ev_second, expire, tick;
  logic             rflag_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] one_c;

  assign core_n   = por_n && core_rst_n;
  assign one_c    = {{(CNT_W-1){1'b0}}, 1'b1};
  assign load_val = one_c << (BASE + 2 * int'(wr_data[F_ISEL +: 2]));

  wdt_regs u_regs (
    .clk       (clk),
    .rst_n     (core_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .expire    (expire),
    .ctl       (ctl),
    .restart   (restart),
    .ev_first  (ev_first),
    .ev_second (ev_second),
    .rst_req   (rst_req)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (core_n),
    .run   (ctl.en),
    .clr   (restart),
    .sel   (ctl.cksel),
    .tick  (tick)
  );

  wdt_downcount #(
    .CNT_W   (CNT_W),
    .GRACE   (GRACE),
    .RST_VAL (1 << BASE)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (core_n),
    .load     (restart),
    .load_val (load_val),
    .grace_go (ev_first),
    .tick     (tick),
    .expire   (expire)
  );

  // reset flag lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rflag_q <= 1'b0;
    end else if (core_rst_n) begin
      rflag_q <= (rflag_q && !(wr_en && wr_data[F_RFLAG])) ||
                 (ev_second && ctl.rst_en);
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[F_CKSEL +: 2] = ctl.cksel;
    rd_data[F_FRZ]        = ctl.frz;
    rd_data[F_EN]         = ctl.en;
    rd_data[F_IE]         = ctl.ie;
    rd_data[F_ISEL +: 2]  = ctl.isel;
    rd_data[F_IFLAG]      = ctl.iflag;
    rd_data[F_RFLAG]      = rflag_q;
    rd_data[F_RSTEN]      = ctl.rst_en;
  end

  assign irq = ctl.iflag && ctl.ie;

  // R7
  req_flag_chk: assert property (@(posedge clk) disable iff (!core_n)
    rst_req |-> rflag_q);
  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!core_n)
    rst_req |=> !rst_req);
  // R10
  rflag_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst_n |=> rflag_q == $past(rflag_q));
endmodule

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
  localparam int BASE  = 4;
  localparam int GRACE = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        core_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;

  always #2.5 clk = ~clk;

  wdt_two_stage #(.BASE(BASE), .GRACE(GRACE)) dut (
    .clk(clk), .por_n(por_n), .core_rst_n(core_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_cksel, m_frz, m_en, m_ie, m_isel, m_iflag, m_rflag, m_rsten, m_req;
  longint m_cnt, m_pre;
  bit rs, tk, ev, first, second;

  function automatic longint divof(int s);
    case (s)
      0: return 1;
      1: return 256;
      2: return 2048;
      default: return 65536;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[11:10] = 2'(m_cksel); v[9] = 1'(m_frz); v[7] = 1'(m_en);
    v[6] = 1'(m_ie); v[5:4] = 2'(m_isel); v[3] = 1'(m_iflag);
    v[2] = 1'(m_rflag); v[1] = 1'(m_rsten);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!por_n || !core_rst_n) begin
      m_cksel = 1; m_frz = 0; m_en = 0; m_ie = 0; m_isel = 0;
      m_iflag = 0; m_rsten = 0; m_req = 0;
      m_cnt = longint'(1) << BASE; m_pre = 0;
      if (!por_n) m_rflag = 0;
    end else begin
      rs     = wr_en && wr_data[0];
      tk     = (m_en != 0) && (m_pre >= divof(m_cksel) - 1);
      ev     = tk && (m_cnt == 1) && !rs;
      first  = ev && (m_iflag == 0);
      second = ev && (m_iflag != 0);
      m_pre  = (m_en == 0 || rs || tk) ? 0 : m_pre + 1;
      if (rs) m_cnt = longint'(1) << (BASE + 2 * int'(wr_data[5:4]));
      else if (first) m_cnt = GRACE;
      else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
      m_req   = (second && m_rsten != 0) ? 1 : 0;
      m_rflag = ((m_rflag != 0 && !(wr_en && wr_data[2])) || (second && m_rsten != 0)) ? 1 : 0;
      m_iflag = ((m_iflag != 0 && !(wr_en && wr_data[3])) || first) ? 1 : 0;
      if (wr_en) begin
        m_cksel = int'(wr_data[11:10]); m_frz = int'(wr_data[9]);
        m_en = int'(wr_data[7]); m_ie = int'(wr_data[6]);
        m_isel = int'(wr_data[5:4]); m_rsten = int'(wr_data[1]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (cmp_on && por_n && core_rst_n) begin
      chk({cur_req, " rd_data"}, rd_data, exp_rd());
      chk("R6 irq", {31'b0, irq}, {31'b0, 1'(m_iflag != 0 && m_ie != 0)});
      chk("R7 rst_req", {31'b0, rst_req}, {31'b0, 1'(m_req)});
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL %s watchdog: actual=%0d cycles expected<=150000", cur_req, cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    por_n = 1'b1; core_rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 reset word", rd_data, 32'h0000_0400);
    chk("R1 irq/rst_req", {30'b0, irq, rst_req}, 32'h0);

    // R2 field readback; reserved and restart bits read 0
    cur_req = "R2";
    wr(32'hFFFF_FE72);
    chk("R2 readback", rd_data, 32'h0000_0E72);
    wr(32'h0000_000C);
    chk("R2 cleared", rd_data, 32'h0000_0000);

    // R3/R5/R7 full two-stage expiry, divider 1, interval 0
    cur_req = "R5";
    wr(32'h0000_00C3);
    chk("R3 restart bit not stored", {31'b0, rd_data[0]}, 32'h0);
    idle(15);
    chk("R5 before first expiry", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R5 first expiry sets flag", {31'b0, rd_data[3]}, 32'h1);
    chk("R6 irq on flag", {31'b0, irq}, 32'h1);
    cur_req = "R7";
    idle(7);
    chk("R7 before grace end", {31'b0, rst_req}, 32'h0);
    idle(1);
    chk("R7 reset request", {31'b0, rst_req}, 32'h1);
    chk("R7 reset flag", {31'b0, rd_data[2]}, 32'h1);
    idle(1);
    chk("R7 pulse one cycle", {31'b0, rst_req}, 32'h0);
    idle(40);
    chk("R7 counter parked", {31'b0, rst_req}, 32'h0);

    // R8 writing 0 keeps flags, writing 1 clears them
    cur_req = "R8";
    wr(32'h0000_00C2);
    chk("R8 zero keeps flags", rd_data & 32'hC, 32'hC);
    wr(32'h0000_00CE);
    chk("R8 one clears flags", rd_data & 32'hC, 32'h0);

    // R6/R7 interval 1, interrupt masked, reset disabled
    cur_req = "R6";
    wr(32'h0000_0091);
    idle(64 + GRACE + 20);
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    chk("R7 no reset flag when disabled", {31'b0, rd_data[2]}, 32'h0);
    wr(32'h0000_0008);

    // R9 pause and resume
    cur_req = "R9";
    wr(32'h0000_00C1);
    idle(4);
    wr(32'h0000_0040);
    idle(30);
    chk("R9 paused no expiry", {31'b0, irq}, 32'h0);
    wr(32'h0000_00C0);
    idle(20);
    chk("R9 resumed to expiry", {31'b0, irq}, 32'h1);
    wr(32'h0000_000C);

    // R4 divider 256 with reset enabled
    cur_req = "R4";
    wr(32'h0000_04C3);
    idle(16 * 256 - 2);
    chk("R4 div256 not yet", {31'b0, irq}, 32'h0);
    idle(4);
    chk("R4 div256 expiry", {31'b0, irq}, 32'h1);
    idle(8 * 256 + 4);
    chk("R4 div256 reset flag", {31'b0, rd_data[2]}, 32'h1);

    // R4 divider 2048
    wr(32'h0000_08C9);
    idle(16 * 2048 - 2);
    chk("R4 div2048 not yet", {31'b0, irq}, 32'h0);
    idle(4);
    chk("R4 div2048 expiry", {31'b0, irq}, 32'h1);

    // R10 core reset keeps reset flag; power-on clears it
    cur_req = "R10";
    @(negedge clk); core_rst_n = 1'b0;
    idle(2);
    core_rst_n = 1'b1;
    @(negedge clk);
    chk("R10 core reset keeps rflag", rd_data, 32'h0000_0404);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(32'h0000_0080);
    idle(17);
    chk("R10 default interval", {31'b0, rd_data[3]}, 32'h1);
    @(negedge clk); por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    @(negedge clk);
    chk("R10 por clears rflag", rd_data, 32'h0000_0400);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule